// File: doc/BRIEF.md
# Time-Division Slot-Table Router Switch

This block is the switching core of a circuit-switched mesh router in a time-division-multiplexed network-on-chip. It has five ports: east, west, north, south and local. Every output owns a small table with one entry per global time slot. An entry says which input, if any, is connected to that output during that slot. No arbitration takes place. Two flows can never meet at an output, because an allocator has already given each of them different slots.

A free-running slot counter steps through the period of S slots, one slot per clock cycle. All tables read the entry for the current slot. The selected input flit is registered, so it leaves the router one slot later than it arrived. A flow that holds slot s on an input therefore occupies slot (s+1) mod S on the output, and the tables of successive routers on a path are offset by one slot per hop. A flow reserves bandwidth by holding several entries per period.

An allocator edits the tables through a configuration port, one (output, slot) entry per cycle. It can set an entry to an input or clear it. A write aimed at the slot being switched in that cycle is dropped, so a connection never changes in the middle of a slot.

Top module: `tdm_slot_router`

## Requirements
- R1: After synchronous reset, every output carries an idle flit (valid 0, data 0), the slot number is 0 and every table entry is empty.
- R2: The slot number rises by one every cycle and wraps from S-1 to 0.
- R3: If output o's entry for slot s names input i and input i carries a valid flit while the slot number is s, that flit appears on output o, unchanged, while the slot number is (s+1) mod S. Port codes are east 0, west 1, north 2, south 3, local 4.
- R4: If output o's entry for slot s is empty, output o carries an idle flit (valid 0, data 0) during slot (s+1) mod S.
- R5: If output o's entry for slot s names an input that carries no valid flit in slot s, output o is idle during slot (s+1) mod S.
- R6: Each output is switched only by its own table. Several outputs may name the same input in the same slot, and each of them then receives a copy of the flit.
- R7: A configuration write with set 1 stores the named input into entry (output, slot), and a write with set 0 empties that entry. The change first acts at the next occurrence of that slot.
- R8: A configuration write whose slot equals the current slot number has no effect.
- R9: A configuration write with an output code of 5 to 7, or a set write with an input code of 5 to 7, has no effect on any table.
- R10: An output whose table names the same input in k slots forwards k flits of that input per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one time slot |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_out | input | 3 | Output port whose table is written |
| cfg_slot | input | SLOT_W | Slot entry to write |
| cfg_set | input | 1 | 1 stores cfg_in, 0 empties the entry |
| cfg_in | input | 3 | Input port to connect |
| in_valid | input | 5 | Per-input flit valid |
| in_data | input | 5 x DATA_W | Per-input flit payload |
| out_valid | output | 5 | Per-output flit valid |
| out_data | output | 5 x DATA_W | Per-output flit payload |
| slot_o | output | SLOT_W | Current global slot number |

## Verification
The bench keeps a shadow copy of every table. It writes entries in the very slot they address, so a design that let those writes land would switch a flit one period too early. It connects one input to two outputs in the same slot, which exposes a crossbar that arbitrates or routes only one copy. It sends illegal output and input codes, which catches a decoder that aliases code 5 onto a real port or stores a source that does not exist. Long random runs compare the slot offset on every port, so an output stage that switches in the same slot or two slots late shows up as wrong data against the expected slot.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int NUM_PORTS = 5;
    localparam int PORT_W    = 3;

    typedef enum logic [PORT_W-1:0] {
        DIR_EAST  = 3'd0,
        DIR_WEST  = 3'd1,
        DIR_NORTH = 3'd2,
        DIR_SOUTH = 3'd3,
        DIR_LOCAL = 3'd4
    } dir_e;

    // One slot-table entry: connection present and its source input.
    typedef struct packed {
        logic              used;
        logic [PORT_W-1:0] src;
    } entry_t;

    function automatic logic port_ok(input logic [PORT_W-1:0] p);
        return p < PORT_W'(NUM_PORTS);
    endfunction

endpackage

// File: rtl/tdm_slot_counter.sv
module tdm_slot_counter #(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot_q
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst)                slot_q <= '0;
        else if (slot_q == LAST) slot_q <= '0;
        else                    slot_q <= slot_q + 1'b1;
    end

    // R2: wrap at the end of the period
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (slot_q == LAST) |=> (slot_q == '0));

    // R2: single step otherwise
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table
    import tdm_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_set,
    input  logic [PORT_W-1:0] wr_src,
    input  logic [SLOT_W-1:0] cur_slot,
    output entry_t            cur_entry
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    entry_t tbl [SLOTS];
    logic   accept;

    // Writes to the slot being switched, out-of-range slots and unknown
    // sources are dropped.
    always_comb begin
        accept = wr_en && (wr_slot != cur_slot) && (wr_slot <= LAST)
                 && (!wr_set || port_ok(wr_src));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SLOTS; k++) tbl[k] <= '0;
        end else if (accept) begin
            tbl[wr_slot].used <= wr_set;
            tbl[wr_slot].src  <= wr_set ? wr_src : '0;
        end
    end

    assign cur_entry = tbl[cur_slot];

    // R8: a write to the current slot leaves that entry untouched
    a_r8_current_slot_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_slot == cur_slot) |=> (tbl[$past(wr_slot)] == $past(tbl[wr_slot])));

    // R9: a set write naming no real input leaves the entry untouched
    a_r9_bad_src_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_set && !port_ok(wr_src) && wr_slot <= LAST)
        |=> (tbl[$past(wr_slot)] == $past(tbl[wr_slot])));

    // R7: an accepted set write is stored
    a_r7_set_stored: assert property (@(posedge clk) disable iff (rst)
        (accept && wr_set) |=> (tbl[$past(wr_slot)].used && tbl[$past(wr_slot)].src == $past(wr_src)));

    // R7: an accepted clear write empties the entry
    a_r7_clear_stored: assert property (@(posedge clk) disable iff (rst)
        (accept && !wr_set) |=> !tbl[$past(wr_slot)].used);

endmodule

// File: rtl/tdm_xbar_port.sv
module tdm_xbar_port
    import tdm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  entry_t                            sel,
    input  logic [NUM_PORTS-1:0]              in_valid,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]  in_data,
    output logic                              out_valid,
    output logic [DATA_W-1:0]                 out_data
);
    logic              nxt_valid;
    logic [DATA_W-1:0] nxt_data;

    always_comb begin
        nxt_valid = 1'b0;
        nxt_data  = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (sel.used && sel.src == PORT_W'(i) && in_valid[i]) begin
                nxt_valid = 1'b1;
                nxt_data  = in_data[i];
            end
        end
    end

    // Output register: one slot of hop latency.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= nxt_valid;
            out_data  <= nxt_data;
        end
    end

    // R4: empty entry gives an idle flit one slot later
    a_r4_idle_when_unused: assert property (@(posedge clk) disable iff (rst)
        !sel.used |=> (!out_valid && out_data == '0));

    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_chk
        // R3: connected valid flit forwarded unchanged next slot
        a_r3_forward: assert property (@(posedge clk) disable iff (rst)
            (sel.used && sel.src == PORT_W'(gi) && in_valid[gi])
            |=> (out_valid && out_data == $past(in_data[gi])));

        // R5: connected but empty input gives an idle flit
        a_r5_no_flit: assert property (@(posedge clk) disable iff (rst)
            (sel.used && sel.src == PORT_W'(gi) && !in_valid[gi]) |=> !out_valid);
    end

endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
    import tdm_pkg::*;
#(
    parameter int SLOTS  = 8,
    parameter int DATA_W = 32,
    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              cfg_we,
    input  logic [2:0]                        cfg_out,
    input  logic [SLOT_W-1:0]                 cfg_slot,
    input  logic                              cfg_set,
    input  logic [2:0]                        cfg_in,
    input  logic [4:0]                        in_valid,
    input  logic [4:0][DATA_W-1:0]            in_data,
    output logic [4:0]                        out_valid,
    output logic [4:0][DATA_W-1:0]            out_data,
    output logic [SLOT_W-1:0]                 slot_o
);
    logic [SLOT_W-1:0] slot_q;
    entry_t            cur_entry [NUM_PORTS];

    tdm_slot_counter #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_counter (
        .clk    (clk),
        .rst    (rst),
        .slot_q (slot_q)
    );

    assign slot_o = slot_q;

    for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out
        logic wr_here;
        assign wr_here = cfg_we && (cfg_out == PORT_W'(go));

        tdm_slot_table #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_table (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_here),
            .wr_slot   (cfg_slot),
            .wr_set    (cfg_set),
            .wr_src    (cfg_in),
            .cur_slot  (slot_q),
            .cur_entry (cur_entry[go])
        );

        tdm_xbar_port #(.DATA_W(DATA_W)) u_port (
            .clk       (clk),
            .rst       (rst),
            .sel       (cur_entry[go]),
            .in_valid  (in_valid),
            .in_data   (in_data),
            .out_valid (out_valid[go]),
            .out_data  (out_data[go])
        );
    end

    // R9: a write with an unknown output code changes no output's entry
    for (genvar gc = 0; gc < NUM_PORTS; gc++) begin : g_r9
        a_r9_bad_out_ignored: assert property (@(posedge clk) disable iff (rst)
            (cfg_we && !port_ok(cfg_out) && cfg_slot == slot_q + 1'b1 && slot_q != SLOT_W'(SLOTS - 1))
            |=> (cur_entry[gc] == $past(g_out[gc].u_table.tbl[cfg_slot])));
    end

endmodule

// File: tb/test_tdm_slot_router.sv
module test_tdm_slot_router;
    localparam int S  = 8;
    localparam int W  = 32;
    localparam int NP = 5;
    localparam int SW = $clog2(S);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_we = 1'b0;
    logic [2:0]         cfg_out = '0;
    logic [SW-1:0]      cfg_slot = '0;
    logic               cfg_set = 1'b0;
    logic [2:0]         cfg_in = '0;
    logic [4:0]         in_valid = '0;
    logic [4:0][W-1:0]  in_data = '0;
    logic [4:0]         out_valid;
    logic [4:0][W-1:0]  out_data;
    logic [SW-1:0]      slot_o;

    int n_chk = 0;
    int n_fail = 0;

    bit m_used [NP][S];
    int m_src  [NP][S];

    always #2 clk = ~clk;

    tdm_slot_router #(.SLOTS(S), .DATA_W(W)) i_tdm_slot_router (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_out(cfg_out),
        .cfg_slot(cfg_slot), .cfg_set(cfg_set), .cfg_in(cfg_in),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .slot_o(slot_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int next_slot(input int s);
        return (s + 1) % S;
    endfunction

    // One slot: predict outputs, update shadow tables, advance, compare.
    task automatic cycle(input string tag);
        int s;
        bit ev [NP];
        logic [W-1:0] ed [NP];
        string rq [NP];
        s = int'(slot_o);
        for (int o = 0; o < NP; o++) begin
            ev[o] = 1'b0; ed[o] = '0;
            if (!m_used[o][s])                rq[o] = "R4";
            else if (!in_valid[m_src[o][s]]) rq[o] = "R5";
            else begin
                rq[o] = "R3";
                ev[o] = 1'b1;
                ed[o] = in_data[m_src[o][s]];
            end
            if (tag != "") rq[o] = tag;
        end
        if (cfg_we && cfg_out < 3'd5 && int'(cfg_slot) != s && (!cfg_set || cfg_in < 3'd5)) begin
            m_used[cfg_out][cfg_slot] = cfg_set;
            m_src[cfg_out][cfg_slot]  = cfg_set ? int'(cfg_in) : 0;
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        chk(int'(slot_o) == next_slot(s), "R2", "slot", slot_o, next_slot(s));
        for (int o = 0; o < NP; o++) begin
            chk(out_valid[o] == ev[o] && out_data[o] == ed[o], rq[o],
                $sformatf("out%0d slot%0d {valid,data}", o, next_slot(s)),
                {out_valid[o], out_data[o]}, {ev[o], ed[o]});
        end
    endtask

    task automatic cfg_write(input int o, input int sl, input bit set, input int src, input string tag);
        while (int'(slot_o) == sl) cycle(tag);
        cfg_we = 1'b1; cfg_out = 3'(o); cfg_slot = SW'(sl); cfg_set = set; cfg_in = 3'(src);
        cycle(tag);
    endtask

    task automatic drive_all(input bit v);
        for (int i = 0; i < NP; i++) begin
            in_valid[i] = v;
            in_data[i]  = $urandom;
        end
    endtask

    task automatic run_period(input string tag);
        for (int k = 0; k < S; k++) begin
            drive_all(1'b1);
            cycle(tag);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7129));
        for (int o = 0; o < NP; o++)
            for (int k = 0; k < S; k++) begin m_used[o][k] = 1'b0; m_src[o][k] = 0; end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(slot_o == '0, "R1", "slot in reset", slot_o, 0);
        chk(out_valid == '0 && out_data == '0, "R1", "outputs in reset", out_valid, 0);
        rst = 1'b0;
        run_period("R1");   // empty tables: all idle even with traffic

        // R7 / R10 / R6: local feeds east in slots 1 and 3, north also in slot 1
        cfg_write(0, 1, 1'b1, 4, "R7");
        cfg_write(0, 3, 1'b1, 4, "R7");
        cfg_write(2, 1, 1'b1, 4, "R6");
        cfg_write(1, 5, 1'b1, 2, "R7");
        run_period("R10");
        run_period("R6");

        // R8: write aimed at the current slot is dropped
        while (int'(slot_o) != 6) cycle("R8");
        cfg_we = 1'b1; cfg_out = 3'd0; cfg_slot = SW'(6); cfg_set = 1'b1; cfg_in = 3'd4;
        cycle("R8");
        run_period("R8");

        // R7: clearing an entry
        cfg_write(0, 3, 1'b0, 0, "R7");
        run_period("R7");

        // R9: illegal input code and illegal output codes
        cfg_write(0, 1, 1'b1, 7, "R9");
        cfg_write(5, 2, 1'b1, 4, "R9");
        cfg_write(7, 4, 1'b1, 1, "R9");
        run_period("R9");

        // R5: connected slots with no traffic
        for (int k = 0; k < S; k++) begin
            drive_all(1'b0);
            cycle("R5");
        end

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < NP; i++) begin
                in_valid[i] = ($urandom % 4) != 0;
                in_data[i]  = $urandom;
            end
            if (($urandom % 10) < 3) begin
                cfg_we   = 1'b1;
                cfg_out  = 3'($urandom % 8);
                cfg_slot = SW'($urandom % S);
                cfg_set  = ($urandom % 3) != 0;
                cfg_in   = 3'($urandom % 8);
            end
            cycle("");
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule